// File: doc/BRIEF.md
# Paired-Register PWM Timer Channel

This block is a single timer channel that draws a pulse-width-modulated waveform from two compare registers, A and B. A control field picks one of them as the period register: when the counter reaches that value on a count tick, the counter returns to zero. The other register marks the duty point. Each register carries its own programmable output level, which is driven onto the waveform pin when its match occurs. A further field selects free-running operation with no clearing source.

The counter advances on ticks produced inside the block. A free-running divider supplies a set of taps. A tap-select field picks one of them, and an edge field makes a tick from the tap's rising edge, its falling edge or both. Software writes the control word, the two compare values and a start bit through a simple write port. Compare values pass through shadow buffers. While the channel runs, the buffers move into the active registers only at the period clear, so a new period and duty take effect together on a clean boundary.

The output side is a four-state machine. OFF holds the counter at zero and drives the initial level. ARMED drives the initial level while PWM mode is on and the start bit is low. RUN counts and applies the match levels. HOLD freezes both the counter and the output after the start bit is cleared. The transitions are: OFF to ARMED when mode is set; ARMED to RUN when start is 1; RUN to HOLD when start is 0; HOLD to RUN when start is 1; and any state to OFF when mode is cleared.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset `pwm_out` is 0, the counter is 0, every control field is 0, the start bit is 0 and the state is OFF.
- R2: A write happens on a rising clock edge while `cfg_we` is 1. The address selects the target: 0 is the control word, 1 is the start bit (bit 0), 2 is compare A and 3 is compare B. The control word fields are: bits 1:0 edge select, bits 4:2 tap select, bits 6:5 clear source, bit 7 PWM mode, bit 8 initial level, bit 9 level on an A match, bit 10 level on a B match.
- R3: Clear source 1 uses A as the period register and 2 uses B. On a tick where the counter equals the period value, the counter returns to 0, so one period lasts (period value + 1) ticks. Values 0 and 3 select free-run, where the counter wraps from all ones to 0.
- R4: Tap t follows divider bit t, which toggles every 2^t clocks. Edge select 0 ticks on the tap's rising edge and 1 on its falling edge, giving one tick every 2^(t+1) clocks. Values 2 and 3 tick on both edges, giving one tick every 2^t clocks.
- R5: On a tick where the counter equals compare A, the output takes the A level on the same edge that advances the counter. A tick where the counter equals compare B drives the B level in the same way.
- R6: The initial level is driven while the state is OFF or ARMED. It is loaded again when the start bit is set to 1 from HOLD.
- R7: Clearing the start bit freezes both the counter and the output. Clearing PWM mode forces the counter to 0.
- R8: When A and B match on the same tick, the output takes the level of the period register. In free-run, A takes precedence.
- R9: While the state is RUN, writes to compare A and B land in shadow buffers. The buffers are copied to the active registers on the period clear, or on the wrap in free-run. In any other state, a write reaches the active register at once.
- R10: A duty value greater than the period value never matches, so the output stays at the period register's level after the first period match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench builds the channel with the default 16-bit counter and the 3-bit tap select. It drives only taps 0 and 1, with every edge setting, so ticks arrive every one, two or four clocks. At those rates periods of a few dozen clocks test period, duty, priority, halt and shadow timing within a short run, measured as clock counts between output edges. With a 16-bit counter, a full free-run wrap takes 65,536 ticks. Free-run mode is therefore checked through its first A-to-B interval only, and the shadow transfer at the wrap is not reached.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int PWM_TAP_W = 3;
    localparam int PWM_DIV_W = 1 << PWM_TAP_W;

    // control word layout (addr 0)
    localparam int CTL_EDGE_LSB = 0;
    localparam int CTL_TAP_LSB  = CTL_EDGE_LSB + 2;
    localparam int CTL_CLR_LSB  = CTL_TAP_LSB + PWM_TAP_W;
    localparam int CTL_MODE_BIT = CTL_CLR_LSB + 2;
    localparam int CTL_INIT_BIT = CTL_MODE_BIT + 1;
    localparam int CTL_LVLA_BIT = CTL_INIT_BIT + 1;
    localparam int CTL_LVLB_BIT = CTL_LVLA_BIT + 1;
    localparam int CTL_USED_W   = CTL_LVLB_BIT + 1;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RUN  = 2'd1;
    localparam logic [1:0] ADDR_CMPA = 2'd2;
    localparam logic [1:0] ADDR_CMPB = 2'd3;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_BOTH2 = 2'd3
    } edge_e;

    typedef enum logic [1:0] {
        CLR_FREE  = 2'd0,
        CLR_A     = 2'd1,
        CLR_B     = 2'd2,
        CLR_FREE2 = 2'd3
    } clr_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } pwm_state_e;

    typedef struct packed {
        edge_e                 edge_sel;
        logic [PWM_TAP_W-1:0]  tap;
        clr_e                  clr;
        logic                  mode;
        logic                  init_lvl;
        logic                  lvl_a;
        logic                  lvl_b;
    } pwm_cfg_t;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             running,
    input  logic             xfer,
    output pwm_cfg_t         cfg,
    output logic             start,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b
);

    pwm_cfg_t         cfg_q;
    logic             start_q;
    logic [CNT_W-1:0] shd_a_q, shd_b_q, act_a_q, act_b_q;
    logic             wr_ctrl, wr_run, wr_a, wr_b;

    assign wr_ctrl = we && (addr == ADDR_CTRL);
    assign wr_run  = we && (addr == ADDR_RUN);
    assign wr_a    = we && (addr == ADDR_CMPA);
    assign wr_b    = we && (addr == ADDR_CMPB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            start_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.edge_sel <= edge_e'(wdata[CTL_EDGE_LSB +: 2]);
                cfg_q.tap      <= wdata[CTL_TAP_LSB +: PWM_TAP_W];
                cfg_q.clr      <= clr_e'(wdata[CTL_CLR_LSB +: 2]);
                cfg_q.mode     <= wdata[CTL_MODE_BIT];
                cfg_q.init_lvl <= wdata[CTL_INIT_BIT];
                cfg_q.lvl_a    <= wdata[CTL_LVLA_BIT];
                cfg_q.lvl_b    <= wdata[CTL_LVLB_BIT];
            end
            if (wr_run) start_q <= wdata[0];
        end
    end

    // shadow buffers always take the write; active copies follow at once
    // when idle, or at the transfer point while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_a_q <= '0;
            shd_b_q <= '0;
            act_a_q <= '0;
            act_b_q <= '0;
        end else begin
            if (wr_a) shd_a_q <= wdata;
            if (wr_b) shd_b_q <= wdata;
            if (!running && wr_a)  act_a_q <= wdata;
            else if (xfer)         act_a_q <= shd_a_q;
            if (!running && wr_b)  act_b_q <= wdata;
            else if (xfer)         act_b_q <= shd_b_q;
        end
    end

    assign cfg   = cfg_q;
    assign start = start_q;
    assign cmp_a = act_a_q;
    assign cmp_b = act_b_q;

    // R9: active compare values only move at a transfer while running
    a_r9_act_a_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !xfer) |=> $stable(act_a_q));
    a_r9_act_b_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !xfer) |=> $stable(act_b_q));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PWM_TAP_W-1:0] tap,
    input  edge_e                edge_sel,
    output logic                 tick
);

    logic [PWM_DIV_W-1:0] div_q;
    logic                 tap_cur, tap_d_q, rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            tap_d_q <= 1'b0;
        end else begin
            div_q   <= div_q + PWM_DIV_W'(1);
            tap_d_q <= tap_cur;
        end
    end

    assign tap_cur = div_q[tap];
    assign rise    = tap_cur && !tap_d_q;
    assign fall    = !tap_cur && tap_d_q;

    always_comb begin
        unique case (edge_sel)
            EDG_RISE:            tick = rise;
            EDG_FALL:            tick = fall;
            EDG_BOTH, EDG_BOTH2: tick = rise || fall;
        endcase
    end

    // R4: single-edge ticks are never on consecutive clocks for a fixed tap
    a_r4_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDG_RISE && tick) |=> !(tick && $stable(tap)));
    a_r4_fall_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDG_FALL && tick) |=> !(tick && $stable(tap)));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             zero,
    input  clr_e             clr,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             hit_a,
    output logic             hit_b,
    output logic             xfer
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             per_hit, wrap, free_run;

    assign free_run = (clr == CLR_FREE) || (clr == CLR_FREE2);
    assign hit_a    = en && (cnt_q == cmp_a);
    assign hit_b    = en && (cnt_q == cmp_b);
    assign per_hit  = ((clr == CLR_A) && hit_a) || ((clr == CLR_B) && hit_b);
    assign wrap     = en && free_run && (cnt_q == CNT_MAX);
    assign xfer     = per_hit || wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (zero)    cnt_q <= '0;
        else if (per_hit) cnt_q <= '0;
        else if (en)      cnt_q <= cnt_q + CNT_W'(1);
    end

    // R3: a period match returns the counter to zero
    a_r3_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> (cnt_q == '0));
    // R7: without a tick the counter holds
    a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !zero) |=> $stable(cnt_q));
    // R7: leaving PWM mode zeroes the counter
    a_r7_cnt_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode,
    input  logic       start,
    input  logic       init_lvl,
    input  logic       lvl_a,
    input  logic       lvl_b,
    input  clr_e       clr,
    input  logic       hit_a,
    input  logic       hit_b,
    output pwm_state_e state,
    output logic       pwm_out
);

    pwm_state_e state_q, state_d;
    logic       out_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!mode) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_ARMED;
                ST_ARMED: if (start)  state_d = ST_RUN;
                ST_RUN:   if (!start) state_d = ST_HOLD;
                ST_HOLD:  if (start)  state_d = ST_RUN;
            endcase
        end
    end

    // output level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (!mode) begin
            out_q <= init_lvl;
        end else begin
            unique case (state_q)
                ST_OFF, ST_ARMED: out_q <= init_lvl;
                ST_HOLD: if (start) out_q <= init_lvl;
                ST_RUN: begin
                    if (clr == CLR_B) begin
                        if (hit_b)      out_q <= lvl_b;
                        else if (hit_a) out_q <= lvl_a;
                    end else begin
                        if (hit_a)      out_q <= lvl_a;
                        else if (hit_b) out_q <= lvl_b;
                    end
                end
            endcase
        end
    end

    assign state   = state_q;
    assign pwm_out = out_q;

    // R6: restart from HOLD reloads the initial level
    a_r6_restart_init: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && mode && start) |=> (out_q == $past(init_lvl)));
    // R7: output frozen while halted
    a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && mode && !start) |=> $stable(out_q));
    // R8: simultaneous matches with A as period source give A's level
    a_r8_period_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode && clr == CLR_A && hit_a && hit_b)
        |=> (out_q == $past(lvl_a)));
    // R5: no tick, no level change while running
    a_r5_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode && !hit_a && !hit_b) |=> $stable(out_q));

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic             pwm_out
);

    pwm_cfg_t         cfg;
    logic             start, tick, en, hit_a, hit_b, xfer, running;
    logic [CNT_W-1:0] cmp_a, cmp_b;
    pwm_state_e       state;

    assign running = (state == ST_RUN);
    assign en      = tick && running;

    pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .running(running), .xfer(xfer),
        .cfg(cfg), .start(start), .cmp_a(cmp_a), .cmp_b(cmp_b)
    );

    pwm_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .tap(cfg.tap),
        .edge_sel(cfg.edge_sel), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .zero(state == ST_OFF),
        .clr(cfg.clr), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .hit_a(hit_a), .hit_b(hit_b), .xfer(xfer)
    );

    pwm_out_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .start(start),
        .init_lvl(cfg.init_lvl), .lvl_a(cfg.lvl_a), .lvl_b(cfg.lvl_b),
        .clr(cfg.clr), .hit_a(hit_a), .hit_b(hit_b),
        .state(state), .pwm_out(pwm_out)
    );

    // R1: the control word must fit in the data width
    initial begin
        a_r1_width_fits: assert (CNT_W >= CTL_USED_W);
    end

endmodule

// File: tb/pwm_pair_timer_tb.sv
module pwm_pair_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_pair_timer #(.CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0]  e;
        logic [2:0]  t;
        logic [1:0]  c;
        logic [15:0] a;
        logic [15:0] b;
        logic        la;
        logic        lb;
        logic [15:0] per;
        logic [15:0] hi;
    } vec_t;

    // edge, tap, clear, A, B, lvlA, lvlB, expected period clks, high clks
    localparam vec_t VECS [5] = '{
        '{2'd2, 3'd0, 2'd1, 16'd9,  16'd3,  1'b0, 1'b1, 16'd10, 16'd6},
        '{2'd0, 3'd0, 2'd1, 16'd7,  16'd2,  1'b0, 1'b1, 16'd16, 16'd10},
        '{2'd1, 3'd1, 2'd1, 16'd4,  16'd1,  1'b0, 1'b1, 16'd20, 16'd12},
        '{2'd2, 3'd1, 2'd2, 16'd5,  16'd11, 1'b1, 1'b0, 16'd24, 16'd12},
        '{2'd3, 3'd0, 2'd1, 16'd15, 16'd0,  1'b0, 1'b1, 16'd16, 16'd15}
    };

    function automatic logic [15:0] mk_ctrl(input logic [1:0] e, input logic [2:0] t,
                                            input logic [1:0] c, input logic m,
                                            input logic i, input logic la, input logic lb);
        return {5'b0, lb, la, i, m, c, t, e};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [1:0] e, input logic [2:0] t, input logic [1:0] c,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic i, input logic la, input logic lb);
        wr(2'd1, 16'd0);
        wr(2'd0, mk_ctrl(e, t, c, 1'b0, i, la, lb));
        wr(2'd0, mk_ctrl(e, t, c, 1'b1, i, la, lb));
        wr(2'd2, a);
        wr(2'd3, b);
        wr(2'd1, 16'd1);
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        prev = pwm_out;
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin ok = 1'b1; break; end
            prev = pwm_out;
        end
    endtask

    task automatic measure(output int per, output int hi);
        bit   ok;
        logic prev;
        wait_rise(ok);
        per = 1; hi = 1; prev = 1'b1;
        if (!ok) begin per = -1; hi = -1; return; end
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (!prev && pwm_out) break;
            per++;
            hi += int'(pwm_out);
            prev = pwm_out;
        end
    endtask

    task automatic count_ones(input int n, output int ones);
        ones = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ones += int'(pwm_out);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int  p, h, ones, hr;
        bit  ok;
        logic lvl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset output", int'(pwm_out), 0);

        // R2 R6: mode on, start low, initial level 1 appears on the pin
        wr(2'd0, mk_ctrl(2'd2, 3'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        chk("R6 armed initial level", int'(pwm_out), 1);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < 5; i++) begin
            setup(VECS[i].e, VECS[i].t, VECS[i].c, VECS[i].a, VECS[i].b,
                  1'b0, VECS[i].la, VECS[i].lb);
            measure(p, h);
            measure(p, h);
            chk($sformatf("R3 R4 period vec%0d", i), p, int'(VECS[i].per));
            chk($sformatf("R5 high time vec%0d", i), h, int'(VECS[i].hi));
        end

        // R3 free-run: A drives 1, B drives 0, first interval is B-A ticks
        setup(2'd2, 3'd0, 2'd0, 16'd3, 16'd6, 1'b0, 1'b1, 1'b0);
        wait_rise(ok);
        hr = ok ? 1 : 0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (!pwm_out) break;
            hr++;
        end
        chk("R3 free-run high interval", hr, 3);

        // R7 halt while high, then R6 restart reloads initial level
        setup(2'd2, 3'd0, 2'd1, 16'd9, 16'd3, 1'b0, 1'b0, 1'b1);
        measure(p, h);
        wait_rise(ok);
        wr(2'd1, 16'd0);
        lvl = pwm_out;
        count_ones(30, ones);
        chk("R7 output held while halted", ones + int'(lvl), 31);
        wr(2'd1, 16'd1);
        @(negedge clk);
        chk("R6 restart loads initial level", int'(pwm_out), 0);

        // R8 simultaneous A and B match: A (period) level 0 wins over B level 1
        setup(2'd2, 3'd0, 2'd1, 16'd5, 16'd5, 1'b1, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        count_ones(40, ones);
        chk("R8 period level wins", ones, 0);

        // R10 duty above period: constant period level
        setup(2'd2, 3'd0, 2'd1, 16'd5, 16'd9, 1'b1, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        count_ones(40, ones);
        chk("R10 duty beyond period", ones, 0);

        // R9 shadow: mid-period write does not disturb the current period
        setup(2'd2, 3'd0, 2'd1, 16'd19, 16'd10, 1'b0, 1'b0, 1'b1);
        measure(p, h);
        wait_rise(ok);
        hr = 1;
        fork
            begin
                for (int n = 0; n < 200; n++) begin
                    @(negedge clk);
                    if (!pwm_out) break;
                    hr++;
                end
            end
            begin
                repeat (3) @(negedge clk);
                wr(2'd2, 16'd12);
                wr(2'd3, 16'd4);
            end
        join
        chk("R9 current period untouched", hr, 9);
        measure(p, h);
        chk("R9 new period after transfer", p * 100 + h, 1308);

        summary();
        $finish;
    end

endmodule